// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block gathers up to 32 interrupt sources and drives one interrupt request line to a processor. Every source passes through a two-stage synchroniser. A build-time mask marks each source as edge-triggered or level-triggered. A triggered source sets a sticky status bit. Software can clear that bit through an acknowledge word. The status bits are masked by an enable word. Software can replace the enable word whole, or change it through separate set-only and clear-only words, so one source can be changed without a read-modify-write sequence.

A vector word gives the number of the lowest pending source. The request line is gated by a small master-control state machine with four states:

- `MS_OFF`: neither control bit is set.
- `MS_GATE`: only the master bit is set.
- `MS_HWONLY`: only the hardware-request bit is set.
- `MS_LIVE`: both bits are set.

A write to the master word moves the machine to the state selected by the written master bit and the new hardware-request bit. The new hardware-request bit is the old one OR the written bit 1. Because of this, the allowed moves are:

- From `MS_OFF` or `MS_GATE`, the machine can go to any state.
- From `MS_HWONLY` or `MS_LIVE`, the machine can only go to `MS_HWONLY` or `MS_LIVE`.
- When there is no write, every state holds.

Register access is synchronous. A write takes effect at the clock edge. Read data is combinational from the word index.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the following read as 0: status, pending, enable and master. The vector reads 0xFFFFFFFF, and `irq_o` is 0.
- R2: A write to the enable word (word 2, byte offset 0x08) replaces all enable bits. Writing 0 disables every source at once.
- R3: A write to the set-enable word (word 4, 0x10) sets each enable bit written as 1. All other enable bits keep their value.
- R4: A write to the clear-enable word (word 5, 0x14) clears each enable bit written as 1. All other enable bits keep their value.
- R5: A source whose bit in `KIND_MASK` is 1 is edge-triggered. It sets its status bit once per rising edge of its synchronised input. Holding the input high does not set the bit again after an acknowledge. Mask bits at or above `N_SRC` have no effect.
- R6: A source whose `KIND_MASK` bit is 0 is level-triggered. It sets its status bit on every cycle the synchronised input is high. An acknowledge has a lasting effect only after the input has gone low.
- R7: Writing 1 to a bit of the acknowledge word (word 3, 0x0C) clears that status bit. Writing 0xFFFFFFFF clears every status bit. A new trigger in the same cycle as an acknowledge wins over the acknowledge.
- R8: The pending word (word 1, 0x04) reads as status AND enable. A disabled source still latches its status bit (status word 0, 0x00).
- R9: The vector word (word 6, 0x18) reads as the index of the lowest-numbered pending source. It reads as 0xFFFFFFFF when nothing is pending.
- R10: The master word (word 7, 0x1C) has the master enable at bit 0 and the hardware-request enable at bit 1. Both bits read back as written. Once bit 1 is set, only reset clears it.
- R11: `irq_o` is 1 exactly when both master bits are set and at least one pending bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Raw interrupt source inputs |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_word | input | 3 | Word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the word at `reg_word` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The properties check the following on every cycle:

- The request line never rises without both master bits and a pending source.
- Pending bits are always a subset of the status bits.
- The vector always names the lowest pending bit, or no bit when nothing is pending.
- The hardware-request bit never falls.
- Set-enable and clear-enable writes act on exactly the bits written as 1.

Some behaviour depends on the timing of the source inputs, so only the directed scenarios can show it:

- An edge source latches once per rising edge, even while the input is held high.
- A level source re-latches after an acknowledge while its input stays high.
- The synchroniser adds its latency before a status bit sets.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    // Word indices of the register port (byte offset divided by four)
    localparam logic [2:0] RW_STATUS = 3'd0;
    localparam logic [2:0] RW_PEND   = 3'd1;
    localparam logic [2:0] RW_ENABLE = 3'd2;
    localparam logic [2:0] RW_ACK    = 3'd3;
    localparam logic [2:0] RW_SET    = 3'd4;
    localparam logic [2:0] RW_CLR    = 3'd5;
    localparam logic [2:0] RW_VECTOR = 3'd6;
    localparam logic [2:0] RW_MASTER = 3'd7;

    // Master-control states, encoded as {hardware-request bit, master bit}
    typedef enum logic [1:0] {
        MS_OFF    = 2'b00,
        MS_GATE   = 2'b01,
        MS_HWONLY = 2'b10,
        MS_LIVE   = 2'b11
    } mstate_t;
endpackage

// File: rtl/ivc_capture.sv
module ivc_capture #(
    parameter int          N_SRC     = 8,
    parameter logic [31:0] KIND_MASK = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] ack_clr,
    output logic [N_SRC-1:0] status
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic s1_q, s2_q, trig;

        // Two-stage synchroniser for the raw input
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= src_i[i];
                s2_q <= s1_q;
            end
        end

        if (KIND_MASK[i]) begin : g_edge
            // Edge kind: trigger only on a rising edge of the synchronised input
            logic prev_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= s2_q;
            end
            assign trig = s2_q & ~prev_q;
        end else begin : g_level
            // Level kind: trigger on every cycle the input is high
            assign trig = s2_q;
        end

        // Sticky status bit; a trigger in the same cycle wins over an acknowledge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status[i] <= 1'b0;
            else        status[i] <= (status[i] & ~ack_clr[i]) | trig;
        end
    end
endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
    parameter int N_SRC = 8,
    parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] pend,
    output logic [IDX_W-1:0] idx,
    output logic             hit
);
    // Scan from the top down so the lowest set bit is the one left in idx
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IDX_W'(i);
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ivc_master_fsm.sv
module ivc_master_fsm
    import ivc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] wbits,
    output logic       m_en,
    output logic       hw_en
);
    mstate_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MS_OFF;
        else        state_q <= state_d;
    end

    // Next-state logic: the hardware-request bit can only be set here, never cleared
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_OFF, MS_GATE: begin
                if (wr) begin
                    unique case (wbits)
                        2'b00:   state_d = MS_OFF;
                        2'b01:   state_d = MS_GATE;
                        2'b10:   state_d = MS_HWONLY;
                        default: state_d = MS_LIVE;
                    endcase
                end
            end
            MS_HWONLY, MS_LIVE: begin
                if (wr) state_d = wbits[0] ? MS_LIVE : MS_HWONLY;
            end
            default: state_d = MS_OFF;
        endcase
    end

    // Output decode from the current state
    always_comb begin
        unique case (state_q)
            MS_OFF:    begin m_en = 1'b0; hw_en = 1'b0; end
            MS_GATE:   begin m_en = 1'b1; hw_en = 1'b0; end
            MS_HWONLY: begin m_en = 1'b0; hw_en = 1'b1; end
            MS_LIVE:   begin m_en = 1'b1; hw_en = 1'b1; end
            default:   begin m_en = 1'b0; hw_en = 1'b0; end
        endcase
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int          N_SRC     = 8,
    parameter logic [31:0] KIND_MASK = 32'hFFFF_FF0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             reg_wr,
    input  logic [2:0]       reg_word,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq_o
);
    localparam int          IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [31:0] VMASK = (N_SRC >= 32) ? 32'hFFFF_FFFF : ((32'd1 << N_SRC) - 32'd1);

    logic [31:0]      enable_q;
    logic [N_SRC-1:0] status;
    logic [31:0]      status32, pend32;
    logic [N_SRC-1:0] ack_clr;
    logic [IDX_W-1:0] vec_idx;
    logic             vec_hit;
    logic             m_en, hw_en;

    // Acknowledge strobe: only the bits written as 1, only on a write to the ack word
    assign ack_clr = (reg_wr && reg_word == RW_ACK) ? reg_wdata[N_SRC-1:0] : '0;

    ivc_capture #(.N_SRC(N_SRC), .KIND_MASK(KIND_MASK)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .ack_clr (ack_clr),
        .status  (status)
    );

    // Enable word: replaced by a full write, or changed by the set-only and clear-only words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (reg_wr) begin
            if (reg_word == RW_ENABLE)   enable_q <= reg_wdata & VMASK;
            else if (reg_word == RW_SET) enable_q <= (enable_q | reg_wdata) & VMASK;
            else if (reg_word == RW_CLR) enable_q <= enable_q & ~reg_wdata;
        end
    end

    assign status32 = 32'(status);
    assign pend32   = status32 & enable_q;

    ivc_prio_enc #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_enc (
        .pend (pend32[N_SRC-1:0]),
        .idx  (vec_idx),
        .hit  (vec_hit)
    );

    ivc_master_fsm u_mst (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr && reg_word == RW_MASTER),
        .wbits (reg_wdata[1:0]),
        .m_en  (m_en),
        .hw_en (hw_en)
    );

    // Combinational read mux; write-only words read as zero
    always_comb begin
        unique case (reg_word)
            RW_STATUS: reg_rdata = status32;
            RW_PEND:   reg_rdata = pend32;
            RW_ENABLE: reg_rdata = enable_q;
            RW_VECTOR: reg_rdata = vec_hit ? 32'(vec_idx) : 32'hFFFF_FFFF;
            RW_MASTER: reg_rdata = {30'd0, hw_en, m_en};
            default:   reg_rdata = 32'd0;
        endcase
    end

    assign irq_o = m_en & hw_en & (|pend32);
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
    import ivc_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             wr,
    input logic [2:0]       word,
    input logic [31:0]      wdata,
    input logic [31:0]      enable,
    input logic [31:0]      status,
    input logic [31:0]      pend,
    input logic             hit,
    input logic [IDX_W-1:0] idx,
    input logic             me,
    input logic             hie
);
    localparam logic [31:0] VMASK = (N_SRC >= 32) ? 32'hFFFF_FFFF : ((32'd1 << N_SRC) - 32'd1);

    // Mask of the bit positions below the reported vector index
    logic [31:0] below;
    always_comb begin
        for (int i = 0; i < 32; i++) below[i] = (i < int'(idx));
    end

    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (me && hie && pend != 32'd0));

    assert_hie_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hie |=> hie);

    assert_pend_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~status) == 32'd0);

    assert_vec_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> pend == 32'd0);

    assert_vec_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pend[idx] && (pend & below) == 32'd0));

    assert_set_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && word == RW_SET) |=> ((enable & $past(wdata & VMASK)) == $past(wdata & VMASK)));

    assert_clr_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && word == RW_CLR) |=> ((enable & $past(wdata)) == 32'd0));
endmodule

bind irq_vector_ctrl ivc_checker #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_o  (irq_o),
    .wr     (reg_wr),
    .word   (reg_word),
    .wdata  (reg_wdata),
    .enable (enable_q),
    .status (status32),
    .pend   (pend32),
    .hit    (vec_hit),
    .idx    (vec_idx),
    .me     (m_en),
    .hie    (hw_en)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_word = 3'd0;
    logic [31:0]   reg_wdata = 32'd0;
    logic [31:0]   reg_rdata;
    logic          irq_o;
    int            checks = 0;
    int            failures = 0;

    always #10 clk = ~clk; // 50 MHz

    // Sources 0..3 are edge kind, 4..7 level kind; upper mask bits are set and must have no effect
    irq_vector_ctrl #(.N_SRC(N), .KIND_MASK(32'hFFFF_FF0F)) uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr(reg_wr),
        .reg_word(reg_word), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] w, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_word = w; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic rd_reg(input logic [2:0] w, output logic [31:0] d);
        @(negedge clk);
        reg_word = w;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd_reg(3'd0, d); chk("R1 status", d, 32'd0);
        rd_reg(3'd2, d); chk("R1 enable", d, 32'd0);
        rd_reg(3'd7, d); chk("R1 master", d, 32'd0);
        rd_reg(3'd6, d); chk("R1 vector", d, 32'hFFFF_FFFF);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr_reg(3'd2, 32'h0000_00A5); rd_reg(3'd2, d); chk("R2 write", d, 32'h0000_00A5);
        wr_reg(3'd4, 32'h0000_0042); rd_reg(3'd2, d); chk("R3 set", d, 32'h0000_00E7);
        wr_reg(3'd5, 32'h0000_0021); rd_reg(3'd2, d); chk("R4 clear", d, 32'h0000_00C6);
        wr_reg(3'd2, 32'd0);         rd_reg(3'd2, d); chk("R2 zero", d, 32'd0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        src[1] = 1'b1; settle();
        rd_reg(3'd0, d); chk("R5 edge latch", d, 32'h0000_0002);
        wr_reg(3'd3, 32'h0000_0002); settle();
        rd_reg(3'd0, d); chk("R5 held high no relatch", d, 32'd0);
        src[1] = 1'b0; settle(); src[1] = 1'b1; settle();
        rd_reg(3'd0, d); chk("R5 second edge", d, 32'h0000_0002);
        src[1] = 1'b0;
        wr_reg(3'd3, 32'hFFFF_FFFF); settle();
    endtask

    task automatic t_level();
        logic [31:0] d;
        src[5] = 1'b1; settle();
        rd_reg(3'd0, d); chk("R6 level latch", d, 32'h0000_0020);
        wr_reg(3'd3, 32'h0000_0020); settle();
        rd_reg(3'd0, d); chk("R6 ack while high", d, 32'h0000_0020);
        src[5] = 1'b0; settle();
        wr_reg(3'd3, 32'h0000_0020);
        rd_reg(3'd0, d); chk("R6 ack after low", d, 32'd0);
    endtask

    task automatic t_pending_vector();
        logic [31:0] d;
        src[2] = 1'b1; src[6] = 1'b1; settle(); src[2] = 1'b0; src[6] = 1'b0; settle();
        rd_reg(3'd0, d); chk("R8 latch while disabled", d, 32'h0000_0044);
        rd_reg(3'd1, d); chk("R8 pending masked", d, 32'd0);
        rd_reg(3'd6, d); chk("R9 none pending", d, 32'hFFFF_FFFF);
        wr_reg(3'd4, 32'h0000_0040);
        rd_reg(3'd6, d); chk("R9 single", d, 32'd6);
        wr_reg(3'd4, 32'h0000_0004);
        rd_reg(3'd1, d); chk("R8 pending", d, 32'h0000_0044);
        rd_reg(3'd6, d); chk("R9 lowest", d, 32'd2);
    endtask

    task automatic t_master();
        logic [31:0] d;
        chk("R11 irq master off", {31'd0, irq_o}, 32'd0);
        wr_reg(3'd7, 32'd1); rd_reg(3'd7, d); chk("R10 me only", d, 32'd1);
        chk("R11 irq me only", {31'd0, irq_o}, 32'd0);
        wr_reg(3'd7, 32'd3); rd_reg(3'd7, d); chk("R10 both", d, 32'd3);
        chk("R11 irq both", {31'd0, irq_o}, 32'd1);
        wr_reg(3'd7, 32'd1); rd_reg(3'd7, d); chk("R10 hie sticky", d, 32'd3);
        wr_reg(3'd7, 32'd0); rd_reg(3'd7, d); chk("R10 me cleared", d, 32'd2);
        chk("R11 irq me off", {31'd0, irq_o}, 32'd0);
        wr_reg(3'd7, 32'd1);
        wr_reg(3'd3, 32'hFFFF_FFFF);
        rd_reg(3'd0, d); chk("R7 ack all", d, 32'd0);
        chk("R11 irq none pending", {31'd0, irq_o}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_edge();
        t_level();
        t_pending_vector();
        t_master();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule